// File: doc/BRIEF.md
# Privileged Address Segment Decoder

This block sorts a 32-bit virtual address into one of five fixed windows and decides, from the privilege mode and the error-level status bit, whether the access is allowed. Accesses to the two kernel direct windows, and to the low user window while the error level is set, are translated inside the block by subtracting a fixed base. Accesses to the other windows are translated by an external TLB. The block raises a lookup request, takes the TLB's answer in the same cycle, and folds it into the result.

When an access fails, the block reports a fault kind and computes new values for three fault registers: the faulting virtual address, a context word that carries the upper address bits, and the entry-high word that keeps its address-space ID and takes the page-pair address bits. All results are registered and appear one cycle after the request. The update strobe is active only in the cycle in which a fault is reported.

Top module: `seg_xlate`

## Requirements
- R1: Every request with `req_valid` high gives `out_valid` high exactly one clock later. Without a request, `out_valid` stays low.
- R2: An address below 0x80000000 with `err_level` high is translated in every mode to the same physical address, with `out_ok` high and no TLB request.
- R3: An address below 0x80000000 with `err_level` low raises `tlb_req` in every mode. On a TLB hit `out_paddr` equals `tlb_paddr`.
- R4: Kernel mode gives 0x80000000–0x9FFFFFFF the physical address (addr − 0x80000000) and 0xA0000000–0xBFFFFFFF the physical address (addr − 0xA0000000), with no TLB request. Other modes get an address error there.
- R5: `priv_mode` is 00 kernel, 01 supervisor, 10 or 11 user. 0xC0000000–0xDFFFFFFF is TLB-mapped for kernel and supervisor. 0xE0000000 and above is TLB-mapped for kernel only.
- R6: A disallowed access reports `out_exc`=2 (address error, store) when `req_write` is high and 1 (address error, load) when it is low. It makes no TLB request.
- R7: `tlb_status` is 00 hit, 01 no match, 10 entry invalid, 11 write-protected. No match gives `out_exc` 4 for a store or 3 for a load, with `out_refill` high. Invalid gives the same codes with `out_refill` low. Write-protected gives 5 for either direction. A hit gives 0.
- R8: Any fault drives `out_paddr` to zero and `out_ok` low. A success drives `out_ok` high and `out_refill` low.
- R9: `upd_en` is high exactly when a fault is reported, and `upd_badva` then equals the request address.
- R10: On a fault, `upd_ctx` bits 22:4 hold address bits 31:13, and all other bits come from `cur_ctx`.
- R11: On a fault, `upd_hi` bits 7:0 come from `cur_hi`, bits 31:13 hold address bits 31:13 (the default 4 KiB page pair), and bits 12:8 are zero.
- R12: With `req_valid` low, `tlb_req` is low, and one cycle later `out_valid` and `upd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| priv_mode | input | 2 | 00 kernel, 01 supervisor, 1x user |
| err_level | input | 1 | Error-level status bit |
| tlb_req | output | 1 | Lookup request to the TLB (combinational) |
| tlb_status | input | 2 | TLB outcome for this cycle's request |
| tlb_paddr | input | 32 | TLB physical address on a hit |
| cur_ctx | input | 32 | Current context register |
| cur_hi | input | 32 | Current entry-high register |
| out_valid | output | 1 | Result valid |
| out_ok | output | 1 | Translation succeeded |
| out_paddr | output | 32 | Physical address, zero on a fault |
| out_exc | output | 3 | Fault kind |
| out_refill | output | 1 | No-match fault flag |
| upd_en | output | 1 | Fault register write strobe |
| upd_badva | output | 32 | New faulting-address value |
| upd_ctx | output | 32 | New context value |
| upd_hi | output | 32 | New entry-high value |

## Verification
The block holds no state between requests, so a wrong window boundary, mode decode or outcome mapping shows up one cycle after the request. It appears as a wrong `out_exc`, a nonzero `out_paddr` on a fault, or a missing or extra `tlb_req` in the request cycle itself. A wrong bit slice in the register updates shows on `upd_ctx` or `upd_hi` in that same result cycle. The sweep therefore covers every mode, error level, direction and TLB outcome at each window edge, so that each of these faults is seen on the first request that reaches it.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int VA_W = 32;

    typedef enum logic [2:0] {
        EXC_NONE     = 3'd0,
        EXC_ADDR_LD  = 3'd1,
        EXC_ADDR_ST  = 3'd2,
        EXC_TLB_LD   = 3'd3,
        EXC_TLB_ST   = 3'd4,
        EXC_TLB_MOD  = 3'd5
    } exc_e;

    typedef enum logic [1:0] {
        TLB_HIT     = 2'd0,
        TLB_MISS    = 2'd1,
        TLB_INVALID = 2'd2,
        TLB_WPROT   = 2'd3
    } tlb_res_e;

    typedef enum logic [2:0] {
        WIN_USER   = 3'd0,
        WIN_KDIR0  = 3'd1,
        WIN_KDIR1  = 3'd2,
        WIN_SUPMAP = 3'd3,
        WIN_KMAP   = 3'd4
    } win_e;

    localparam logic [VA_W-1:0] KDIR0_BASE = 32'h8000_0000;
    localparam logic [VA_W-1:0] KDIR1_BASE = 32'hA000_0000;

    typedef struct packed {
        logic            valid;
        logic            ok;
        logic [VA_W-1:0] paddr;
        exc_e            exc;
        logic            refill;
        logic            upd_en;
        logic [VA_W-1:0] badva;
        logic [VA_W-1:0] ctx;
        logic [VA_W-1:0] hi;
    } res_t;
endpackage

// File: rtl/seg_classify.sv
module seg_classify
    import seg_pkg::*;
(
    input  logic [VA_W-1:0] addr,
    input  logic [1:0]      mode,
    input  logic            err_level,
    output win_e            win,
    output logic            allowed,
    output logic            mapped,
    output logic [VA_W-1:0] direct_pa
);
    logic is_kernel;
    logic is_super;

    always_comb begin
        is_kernel = (mode == 2'b00);
        is_super  = (mode == 2'b01);
        win       = WIN_USER;
        allowed   = 1'b0;
        mapped    = 1'b0;
        direct_pa = '0;
        unique case (addr[31:29])
            3'b000, 3'b001, 3'b010, 3'b011: begin
                win       = WIN_USER;
                allowed   = 1'b1;
                mapped    = !err_level;
                direct_pa = addr;
            end
            3'b100: begin
                win       = WIN_KDIR0;
                allowed   = is_kernel;
                direct_pa = addr - KDIR0_BASE;
            end
            3'b101: begin
                win       = WIN_KDIR1;
                allowed   = is_kernel;
                direct_pa = addr - KDIR1_BASE;
            end
            3'b110: begin
                win     = WIN_SUPMAP;
                allowed = is_kernel || is_super;
                mapped  = 1'b1;
            end
            default: begin
                win     = WIN_KMAP;
                allowed = is_kernel;
                mapped  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/seg_fault_map.sv
module seg_fault_map
    import seg_pkg::*;
(
    input  logic     allowed,
    input  logic     mapped,
    input  logic     is_write,
    input  tlb_res_e tlb_res,
    output exc_e     exc,
    output logic     refill
);
    always_comb begin
        exc    = EXC_NONE;
        refill = 1'b0;
        if (!allowed) begin
            exc = is_write ? EXC_ADDR_ST : EXC_ADDR_LD;
        end else if (mapped) begin
            unique case (tlb_res)
                TLB_HIT:     exc = EXC_NONE;
                TLB_MISS: begin
                    exc    = is_write ? EXC_TLB_ST : EXC_TLB_LD;
                    refill = 1'b1;
                end
                TLB_INVALID: exc = is_write ? EXC_TLB_ST : EXC_TLB_LD;
                default:     exc = EXC_TLB_MOD;
            endcase
        end
    end
endmodule

// File: rtl/seg_fault_regs.sv
module seg_fault_regs
    import seg_pkg::*;
#(
    parameter int PAGE_SHIFT = 12,
    parameter int ID_W       = 8
) (
    input  logic [VA_W-1:0] addr,
    input  logic [VA_W-1:0] cur_ctx,
    input  logic [VA_W-1:0] cur_hi,
    output logic [VA_W-1:0] badva,
    output logic [VA_W-1:0] ctx,
    output logic [VA_W-1:0] hi
);
    localparam int              CTX_SHIFT = 9;
    localparam logic [VA_W-1:0] CTX_MASK  = 32'h007F_FFF0;
    localparam logic [VA_W-1:0] PAIR_MASK = ~((32'd1 << (PAGE_SHIFT + 1)) - 32'd1);
    localparam logic [VA_W-1:0] ID_MASK   = (32'd1 << ID_W) - 32'd1;

    always_comb begin
        badva = addr;
        ctx   = (cur_ctx & ~CTX_MASK) | ((addr >> CTX_SHIFT) & CTX_MASK);
        hi    = (addr & PAIR_MASK) | (cur_hi & ID_MASK);
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_pkg::*;
#(
    parameter int PAGE_SHIFT = 12,
    parameter int ID_W       = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    input  logic        req_write,
    input  logic [1:0]  priv_mode,
    input  logic        err_level,
    output logic        tlb_req,
    input  logic [1:0]  tlb_status,
    input  logic [31:0] tlb_paddr,
    input  logic [31:0] cur_ctx,
    input  logic [31:0] cur_hi,
    output logic        out_valid,
    output logic        out_ok,
    output logic [31:0] out_paddr,
    output logic [2:0]  out_exc,
    output logic        out_refill,
    output logic        upd_en,
    output logic [31:0] upd_badva,
    output logic [31:0] upd_ctx,
    output logic [31:0] upd_hi
);
    win_e            win;
    logic            allowed;
    logic            mapped;
    logic [VA_W-1:0] direct_pa;
    exc_e            exc;
    logic            refill;
    logic [VA_W-1:0] nbadva, nctx, nhi;
    res_t            res_d, res_q;

    seg_classify u_cls (
        .addr      (req_addr),
        .mode      (priv_mode),
        .err_level (err_level),
        .win       (win),
        .allowed   (allowed),
        .mapped    (mapped),
        .direct_pa (direct_pa)
    );

    seg_fault_map u_map (
        .allowed  (allowed),
        .mapped   (mapped),
        .is_write (req_write),
        .tlb_res  (tlb_res_e'(tlb_status)),
        .exc      (exc),
        .refill   (refill)
    );

    seg_fault_regs #(.PAGE_SHIFT(PAGE_SHIFT), .ID_W(ID_W)) u_regs (
        .addr    (req_addr),
        .cur_ctx (cur_ctx),
        .cur_hi  (cur_hi),
        .badva   (nbadva),
        .ctx     (nctx),
        .hi      (nhi)
    );

    assign tlb_req = req_valid && allowed && mapped;

    always_comb begin
        res_d        = '0;
        res_d.exc    = EXC_NONE;
        res_d.valid  = req_valid;
        if (req_valid) begin
            if (exc == EXC_NONE) begin
                res_d.ok    = 1'b1;
                res_d.paddr = mapped ? tlb_paddr : direct_pa;
            end else begin
                res_d.exc    = exc;
                res_d.refill = refill;
                res_d.upd_en = 1'b1;
                res_d.badva  = nbadva;
                res_d.ctx    = nctx;
                res_d.hi     = nhi;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q     <= '0;
            res_q.exc <= EXC_NONE;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid  = res_q.valid;
    assign out_ok     = res_q.ok;
    assign out_paddr  = res_q.paddr;
    assign out_exc    = res_q.exc;
    assign out_refill = res_q.refill;
    assign upd_en     = res_q.upd_en;
    assign upd_badva  = res_q.badva;
    assign upd_ctx    = res_q.ctx;
    assign upd_hi     = res_q.hi;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        req_write,
    input logic [1:0]  priv_mode,
    input logic        tlb_req,
    input logic [31:0] cur_ctx,
    input logic        out_valid,
    input logic        out_ok,
    input logic [31:0] out_paddr,
    input logic [2:0]  out_exc,
    input logic        upd_en,
    input logic [31:0] upd_badva,
    input logic [31:0] upd_ctx
);
    a_r1_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    a_r4_direct_needs_kernel: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && priv_mode != 2'b00 && req_addr[31:30] == 2'b10)
            |=> (out_exc == 3'd1 || out_exc == 3'd2));

    a_r6_no_lookup_direct: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_req |-> (req_addr[31:30] != 2'b10));

    a_r6_store_error_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && priv_mode == 2'b10 && req_addr[31])
            |=> (out_exc == 3'd2));

    a_r8_fault_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_exc != 3'd0) |-> (out_paddr == 32'd0 && !out_ok));

    a_r9_badva_latched: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> (out_valid && upd_badva == $past(req_addr)));

    a_r10_ctx_keeps_rest: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> (upd_ctx[3:0] == $past(cur_ctx[3:0])
                    && upd_ctx[31:23] == $past(cur_ctx[31:23])));

    a_r12_idle_no_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !tlb_req);
endmodule

bind seg_xlate seg_xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_write (req_write),
    .priv_mode (priv_mode),
    .tlb_req   (tlb_req),
    .cur_ctx   (cur_ctx),
    .out_valid (out_valid),
    .out_ok    (out_ok),
    .out_paddr (out_paddr),
    .out_exc   (out_exc),
    .upd_en    (upd_en),
    .upd_badva (upd_badva),
    .upd_ctx   (upd_ctx)
);

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  priv_mode = 2'b00;
    logic        err_level = 1'b0;
    logic        tlb_req;
    logic [1:0]  tlb_status = 2'b00;
    logic [31:0] tlb_paddr = '0;
    logic [31:0] cur_ctx = '0;
    logic [31:0] cur_hi = '0;
    logic        out_valid, out_ok, out_refill, upd_en;
    logic [31:0] out_paddr, upd_badva, upd_ctx, upd_hi;
    logic [2:0]  out_exc;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    seg_xlate dut (.*);

    task automatic chk(input bit good, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [31:0] addrs [11] = '{32'h0000_0000, 32'h1234_5678, 32'h7FFF_FFFF,
                                32'h8000_0000, 32'h9FFF_FFFF, 32'hA000_0000,
                                32'hBFFF_FFFF, 32'hC000_0000, 32'hDFFF_FFFF,
                                32'hE000_0000, 32'hFFFF_FFFF};

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R12 reset valid", {31'd0, out_valid}, 32'd0);
        chk(upd_en == 1'b0, "R12 reset upd", {31'd0, upd_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int m = 0; m < 4; m++)
        for (int e = 0; e < 2; e++)
        for (int w = 0; w < 2; w++)
        for (int t = 0; t < 4; t++)
        for (int a = 0; a < 11; a++) begin
            logic [31:0] ad, epa, ectx, ehi;
            bit kern, sup, allow, mapd, erefill;
            int eexc;
            string ptag;
            ad   = addrs[a] ^ {20'd0, 4'(m * 3 + t), 8'd0};
            kern = (m == 0);
            sup  = (m == 1);
            epa  = 32'd0;
            if (ad < 32'h8000_0000) begin
                allow = 1; mapd = (e == 0); epa = ad;
                ptag = (e == 1) ? "R2" : "R3";
            end else if (ad < 32'hA000_0000) begin
                allow = kern; mapd = 0; epa = ad - 32'h8000_0000; ptag = "R4";
            end else if (ad < 32'hC000_0000) begin
                allow = kern; mapd = 0; epa = ad - 32'hA000_0000; ptag = "R4";
            end else if (ad < 32'hE000_0000) begin
                allow = kern || sup; mapd = 1; ptag = "R5";
            end else begin
                allow = kern; mapd = 1; ptag = "R5";
            end
            eexc = 0; erefill = 0;
            if (!allow) eexc = w ? 2 : 1;
            else if (mapd) begin
                epa = ad ^ 32'h5A5A_5000;
                case (t)
                    1: begin eexc = w ? 4 : 3; erefill = 1; end
                    2: eexc = w ? 4 : 3;
                    3: eexc = 5;
                    default: eexc = 0;
                endcase
            end
            if (eexc != 0) epa = 32'd0;
            req_valid  = 1'b1;
            req_addr   = ad;
            req_write  = w[0];
            priv_mode  = 2'(m);
            err_level  = e[0];
            tlb_status = 2'(t);
            tlb_paddr  = ad ^ 32'h5A5A_5000;
            cur_ctx    = 32'hDEAD_BEEF ^ {ad[15:0], ad[31:16]};
            cur_hi     = 32'h1F2E_3D00 | 32'(a * 17 + t);
            ectx = (cur_ctx & 32'hFF80_000F) | {9'd0, ad[31:13], 4'd0};
            ehi  = {ad[31:13], 5'd0, cur_hi[7:0]};
            #1;
            chk(tlb_req == (allow && mapd), (!allow) ? "R6 lookup" : ptag,
                {31'd0, tlb_req}, {31'd0, allow && mapd});
            @(posedge clk); #2;
            chk(out_valid == 1'b1, "R1 valid", {31'd0, out_valid}, 32'd1);
            chk(out_paddr == epa, (eexc != 0) ? "R8 paddr" : ptag, out_paddr, epa);
            chk(out_ok == (eexc == 0), "R8 ok", {31'd0, out_ok}, {31'd0, eexc == 0});
            chk(out_exc == 3'(eexc), (!allow) ? "R6 exc" : (mapd ? "R7 exc" : ptag),
                {29'd0, out_exc}, 32'(eexc));
            chk(out_refill == erefill, "R7 refill", {31'd0, out_refill}, {31'd0, erefill});
            chk(upd_en == (eexc != 0), "R9 upd_en", {31'd0, upd_en}, {31'd0, eexc != 0});
            if (eexc != 0) begin
                chk(upd_badva == ad, "R9 badva", upd_badva, ad);
                chk(upd_ctx == ectx, "R10 ctx", upd_ctx, ectx);
                chk(upd_hi == ehi, "R11 hi", upd_hi, ehi);
            end
            @(negedge clk);
        end
        // R12: idle cycle with a fault-provoking address pattern
        req_valid = 1'b0; req_addr = 32'hFFFF_FFFF; priv_mode = 2'b10; tlb_status = 2'd1;
        #1;
        chk(tlb_req == 1'b0, "R12 idle lookup", {31'd0, tlb_req}, 32'd0);
        @(posedge clk); #2;
        chk(out_valid == 1'b0, "R12 idle valid", {31'd0, out_valid}, 32'd0);
        chk(upd_en == 1'b0, "R12 idle upd", {31'd0, upd_en}, 32'd0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule